// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller with Shared Pullup Control

This block produces the control signals for a bank of general-purpose I/O pins. Two writable registers sit behind a small synchronous register bus. A direction register chooses, pin by pin, whether the pin drives or listens. A data register does two jobs. On a driving pin, its bit is the level placed on the pad. On a listening pin, the same bit switches the weak pullup on (1) or off (0). A third, read-only register returns the pad levels after they have passed through a synchroniser.

The pad cell and the tristate buffer lie outside this block. They take three per-pin outputs: drive enable, drive value and pullup enable. Software sets the pad function by writing the two registers. Changing direction never disturbs the stored data bits, so the value that was driven becomes the pullup setting when the pin turns to input, and it is driven again when the pin turns back to output. The register bus is plain control access, with no flow control. A write lands at the next clock edge, and a read returns the addressed register combinationally in the same cycle.

Top module: `gpio_pullup_port`

## Requirements
- R1: After reset the data and direction registers read 00h, and every pin has drive enable 0, drive value 0 and pullup enable 0.
- R2: A write with address 0 (data register) updates that register at the next rising clock edge, and a read at address 0 returns the stored value.
- R3: A write with address 1 (direction register, bit = 1 means output) updates that register at the next rising clock edge, and a read at address 1 returns it.
- R4: For a pin whose direction bit is 1, drive enable is 1, drive value equals the data bit, and pullup enable is 0.
- R5: For a pin whose direction bit is 0, drive enable is 0, drive value is 0, and pullup enable equals the data bit.
- R6: A read at address 0 returns the stored data bits, not the pad levels, even when the pads differ.
- R7: Writing the direction register leaves the data register contents unchanged.
- R8: A read at address 2 returns the pad inputs delayed through a two-stage synchroniser: a pad change is visible after the second rising edge and not after the first.
- R9: Address 2 is read-only. A write to it changes neither the data register nor the direction register.
- R10: Address 3 reads as 00h, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 pad sample, 3 reserved |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| pad_in | input | 8 | Raw, asynchronous pad levels |
| pad_oe | output | 8 | Per-pin drive enable |
| pad_out | output | 8 | Per-pin drive value |
| pad_pu | output | 8 | Per-pin weak pullup enable |

## Verification
The pad-control function is tried with a table of direction/data pairs. The table covers all pins output, all pins input, alternating masks and masks that overlap partially. A mix of directions shows whether the data bits are routed to the drive value on output pins and to the pullup on input pins, and not the other way round. Directed cases hold the pads opposite to the stored data, to separate data readback from pad readback. They also flip the direction while watching the data bits, and they time a pad edge through the synchroniser, edge by edge. Writes to the read-only and reserved addresses are followed at once by readback of both writable registers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PINS = 2'd2,
    SEL_RSVD = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  data_q,
  output logic [PIN_W-1:0]  dir_q
);
  logic hit_data;
  logic hit_dir;

  assign hit_data = bus_wr && (bus_addr == SEL_DATA);
  assign hit_dir  = bus_wr && (bus_addr == SEL_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (hit_data) begin
      data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (hit_dir) begin
      dir_q <= bus_wdata;
    end
  end

  // R1: registers leave reset cleared
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (data_q == '0 && dir_q == '0));

  // R2: data write lands on the next edge
  a_r2_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_DATA) |=> (data_q == $past(bus_wdata)));

  // R7: direction writes do not disturb data
  a_r7_dir_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_DIR) |=> $stable(data_q));

  // R9 and R10: writes to pad-sample or reserved address touch nothing
  a_r9_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == SEL_PINS || bus_addr == SEL_RSVD))
      |=> ($stable(data_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned PIN_W  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] raw_in,
  output logic [PIN_W-1:0] synced
);
  localparam int unsigned LAST = STAGES - 1;

  logic [PIN_W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain[0] <= '0;
    end else begin
      chain[0] <= raw_in;
    end
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[k] <= '0;
      end else begin
        chain[k] <= chain[k-1];
      end
    end

    // R8: each stage is its predecessor one cycle late
    a_r8_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
      chain[k] == $past(chain[k-1]));
  end

  assign synced = chain[LAST];
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
  parameter int unsigned PIN_W = 8
) (
  input  logic [PIN_W-1:0] data_q,
  input  logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] pad_oe,
  output logic [PIN_W-1:0] pad_out,
  output logic [PIN_W-1:0] pad_pu
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    always_comb begin
      pad_oe[i] = dir_q[i];
      if (dir_q[i]) begin
        pad_out[i] = data_q[i];
        pad_pu[i]  = 1'b0;
      end else begin
        pad_out[i] = 1'b0;
        pad_pu[i]  = data_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_pullup_port.sv
module gpio_pullup_port
  import gpio_pkg::*;
#(
  parameter int unsigned PIN_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_oe,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_pu
);
  logic [PIN_W-1:0] data_q;
  logic [PIN_W-1:0] dir_q;
  logic [PIN_W-1:0] pins_q;

  gpio_regfile #(.PIN_W(PIN_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .data_q    (data_q),
    .dir_q     (dir_q)
  );

  gpio_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (pad_in),
    .synced (pins_q)
  );

  gpio_padctl #(.PIN_W(PIN_W)) u_pad (
    .data_q  (data_q),
    .dir_q   (dir_q),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .pad_pu  (pad_pu)
  );

  always_comb begin
    unique case (bus_addr)
      SEL_DATA: bus_rdata = data_q;
      SEL_DIR:  bus_rdata = dir_q;
      SEL_PINS: bus_rdata = pins_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R4 and R5: a pin never drives and pulls up at once
  a_r5_pu_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);
endmodule

// File: tb/sim_gpio_pullup_port.sv
module sim_gpio_pullup_port;
  localparam int W = 8;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{
    {8'hFF, 8'hA5},   // {dir, data}: all output
    {8'h00, 8'h5A},   // all input
    {8'hF0, 8'hCC},
    {8'h0F, 8'hCC},
    {8'hAA, 8'hFF},
    {8'h55, 8'h0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_oe, pad_out, pad_pu;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  gpio_pullup_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    pad_in = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); chk("R1 data", v, 8'h00);
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 out", pad_out, 8'h00);
    chk("R1 pu", pad_pu, 8'h00);

    // vector table: R2 R3 R4 R5
    for (int n = 0; n < NV; n++) begin
      logic [W-1:0] dv, dd;
      dv = VEC[n][15:8]; dd = VEC[n][7:0];
      wr(2'd0, dd);
      wr(2'd1, dv);
      rd(2'd0, v); chk("R2 data readback", v, dd);
      rd(2'd1, v); chk("R3 dir readback", v, dv);
      chk("R4 oe", pad_oe, dv);
      chk("R4 out", pad_out, dd & dv);
      chk("R5 pu", pad_pu, dd & ~dv);
    end

    // R6 data readback ignores pads
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h81);
    pad_in = 8'h7E;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R6 data not pads", v, 8'h81);

    // R7 direction flips keep data
    wr(2'd1, 8'h00);
    rd(2'd0, v); chk("R7 data after dir=00", v, 8'h81);
    chk("R7 pu follows kept data", pad_pu, 8'h81);
    wr(2'd1, 8'hFF);
    rd(2'd0, v); chk("R7 data after dir=FF", v, 8'h81);
    chk("R7 out follows kept data", pad_out, 8'h81);

    // R8 synchroniser latency
    @(negedge clk);
    bus_addr = 2'd2;
    #1 chk("R8 settled pads", bus_rdata, 8'h7E);
    pad_in = 8'hA5;
    @(posedge clk); #1 chk("R8 after one edge", bus_rdata, 8'h7E);
    @(posedge clk); #1 chk("R8 after two edges", bus_rdata, 8'hA5);

    // R9 write to pad-sample address ignored
    wr(2'd2, 8'h42);
    rd(2'd0, v); chk("R9 data", v, 8'h81);
    rd(2'd1, v); chk("R9 dir", v, 8'hFF);
    rd(2'd2, v); chk("R9 pads", v, 8'hA5);

    // R10 reserved address
    wr(2'd3, 8'h99);
    rd(2'd3, v); chk("R10 reads zero", v, 8'h00);
    rd(2'd0, v); chk("R10 data", v, 8'h81);
    rd(2'd1, v); chk("R10 dir", v, 8'hFF);

    // R1 reset again clears registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, v); chk("R1 data after re-reset", v, 8'h00);
    chk("R1 pu after re-reset", pad_pu, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule